// File: doc/BRIEF.md
# SDRAM Burst Page Command Sequencer

This block takes one host transfer that is wider than the SDRAM data port and turns it into a sequence of SDRAM commands on the pin-level command and address bus. It opens the addressed row with a single ACTIVE command. After a programmable delay it issues one column READ or WRITE on every clock, one per port-width beat. It generates each beat's column address itself, with the device kept at burst length one. It then closes the page with a precharge-all command and waits a fixed recovery time before it accepts the next request.

The host presents a byte address, a read/write flag, a transfer size (a power-of-two beat count) and a latency code, and holds `reqValid` until the block accepts the request. A one-cycle `done` pulse marks the precharge. For writes, `wrAccept` tells the host in which cycles to present data. For reads, `rdValid` marks the cycles in which read data arrives.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held and after release with no request, `sdCsN` is 1, the command pins read NOP, `reqReady` is 1, and `done`, `wrAccept` and `rdValid` are 0.
- R2: Commands use {RAS#,CAS#,WE#} = ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, NOP 111. `sdCsN` is 0 in every cycle from the ACTIVE through the end of the precharge wait. In those cycles `sdAddr` is 0 whenever the command is NOP.
- R3: Each transfer issues exactly one ACTIVE, in the cycle after acceptance. `sdAddr` carries the row (host address bits [21:10]) and `sdBa` the bank (bits [23:22]). No column command is issued without an open row.
- R4: The first column command follows the ACTIVE by `casLat`+1 clocks (codes 00, 01, 10, 11 give 1, 2, 3, 4). The code is sampled when the request is accepted.
- R5: A transfer of size code s (00, 01, 10, 11) issues 2^s column commands, one per clock with no gaps.
- R6: The first column address is host address bits [9:2]. Each later beat adds one, wrapping inside the aligned block of 2^s columns. `sdAddr[10]` is 0 on every column command.
- R7: In the clock after the last column command the block issues PRECHARGE with `sdAddr[10]` = 1.
- R8: `done` is high for exactly the precharge cycle of each transfer.
- R9: `reqReady` is high only while idle. It returns PRE_WAIT (default 2) clocks after the precharge cycle. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
- R10: `wrAccept` is high in each WRITE cycle. `rdValid` is high `casLat`+1 clocks after each READ.
- R11: `sdBa` holds the transfer's bank from ACTIVE through the precharge wait. It is 0 while idle.
- R12: Changes of `reqValid`, `reqAddr`, `reqWrite`, `reqSize` or `casLat` while `reqReady` is low do not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle and able to accept |
| reqWrite | input | 1 | 1 = write transfer, 0 = read |
| reqAddr | input | 24 | Host byte address: bank, row, column, byte offset |
| reqSize | input | 2 | log2 of beat count |
| casLat | input | 2 | Latency code, delay = code + 1 clocks |
| done | output | 1 | One-cycle pulse in the precharge cycle |
| wrAccept | output | 1 | Host write data taken this cycle |
| rdValid | output | 1 | Read data present this cycle |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank select |
| sdAddr | output | 12 | Row, column or precharge-qualifier address |

## Verification
The main sequence runs over every pairing of latency code and size code, once as a read and once as a write. Those runs separate a wrong ACTIVE-to-column delay from a wrong beat count, and a wrong read-strobe latency from a wrong write strobe. Random start columns, plus one eight-beat case starting mid-block, distinguish a wrapping column counter from a plain incrementing one. Requests held pending through a busy transfer, with different fields, show whether the block samples inputs only at acceptance. Idle gaps compared with back-to-back requests expose errors in the precharge wait and in the ready timing.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_RCD, S_COL, S_PRE, S_RP
  } seq_state_e;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE
  } sd_cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;     // capture host request
    logic    advance;  // step to next beat
    logic    busy;     // transfer in progress
    sd_cmd_e cmd;      // command driven this cycle
  } seq_strobe_t;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int LAT_W    = 2,
  parameter int PRE_WAIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             writeQ,
  input  logic             lastBeat,
  input  logic [LAT_W-1:0] casLatQ,
  output seq_strobe_t      st,
  output logic             reqReady,
  output logic             done
);

  localparam int CNT_W = $clog2(PRE_WAIT + (1 << LAT_W) + 1);

  seq_state_e state;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    st.load    = 1'b0;
    st.advance = 1'b0;
    st.busy    = (state != S_IDLE);
    st.cmd     = C_NOP;
    case (state)
      S_IDLE: st.load = reqValid;
      S_ACT:  st.cmd  = C_ACT;
      S_COL: begin
        st.cmd     = writeQ ? C_WR : C_RD;
        st.advance = 1'b1;
      end
      S_PRE:  st.cmd  = C_PRE;
      default: ;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_PRE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) state <= S_ACT;
        S_ACT: begin
          if (casLatQ == '0) state <= S_COL;
          else begin
            waitCnt <= CNT_W'(casLatQ);
            state   <= S_RCD;
          end
        end
        S_RCD: begin
          if (waitCnt == CNT_W'(1)) state <= S_COL;
          waitCnt <= waitCnt - 1'b1;
        end
        S_COL: if (lastBeat) state <= S_PRE;
        S_PRE: begin
          if (PRE_WAIT == 0) state <= S_IDLE;
          else begin
            waitCnt <= CNT_W'(PRE_WAIT);
            state   <= S_RP;
          end
        end
        S_RP: begin
          if (waitCnt == CNT_W'(1)) state <= S_IDLE;
          waitCnt <= waitCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbs_dpath.sv
module sbs_dpath
  import sbs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int BYTE_W = 2,
  parameter int SZ_W   = 2,
  parameter int LAT_W  = 2
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  seq_strobe_t                             st,
  input  logic [BYTE_W+COL_W+ROW_W+BANK_W-1:0]    reqAddr,
  input  logic                                    reqWrite,
  input  logic [SZ_W-1:0]                         reqSize,
  input  logic [LAT_W-1:0]                        casLat,
  output logic                                    writeQ,
  output logic                                    lastBeat,
  output logic [LAT_W-1:0]                        casLatQ,
  output logic                                    wrAccept,
  output logic                                    rdValid,
  output logic                                    sdCsN,
  output logic                                    sdRasN,
  output logic                                    sdCasN,
  output logic                                    sdWeN,
  output logic [BANK_W-1:0]                       sdBa,
  output logic [ROW_W-1:0]                        sdAddr
);

  localparam int HOST_AW   = BYTE_W + COL_W + ROW_W + BANK_W;
  localparam int ADDR_W    = ROW_W;
  localparam int BEAT_W    = (1 << SZ_W) - 1;
  localparam int RD_DEPTH  = 1 << LAT_W;
  localparam int QUAL_BIT  = 10;
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << QUAL_BIT;

  logic [ROW_W-1:0]    rowQ;
  logic [COL_W-1:0]    colQ, colNext, colMask;
  logic [BANK_W-1:0]   bankQ;
  logic [SZ_W-1:0]     sizeQ;
  logic [BEAT_W-1:0]   beatCnt, beatMask;
  logic [RD_DEPTH-1:0] rdPipe;
  logic [ADDR_W-1:0]   colBus;
  logic [2:0]          rcw;

  wire unusedByteBits = ^reqAddr[BYTE_W-1:0];

  // wrap the column inside the aligned block of the transfer
  assign colMask  = ~({COL_W{1'b1}} << sizeQ);
  assign colNext  = (colQ & ~colMask) | ((colQ + 1'b1) & colMask);
  assign beatMask = ~({BEAT_W{1'b1}} << sizeQ);
  assign lastBeat = (beatCnt == beatMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ    <= '0;
      colQ    <= '0;
      bankQ   <= '0;
      sizeQ   <= '0;
      writeQ  <= 1'b0;
      casLatQ <= '0;
      beatCnt <= '0;
      rdPipe  <= '0;
    end else begin
      rdPipe <= {rdPipe[RD_DEPTH-2:0], st.cmd == C_RD};
      if (st.load) begin
        colQ    <= reqAddr[BYTE_W +: COL_W];
        rowQ    <= reqAddr[BYTE_W+COL_W +: ROW_W];
        bankQ   <= reqAddr[HOST_AW-1 -: BANK_W];
        sizeQ   <= reqSize;
        writeQ  <= reqWrite;
        casLatQ <= casLat;
        beatCnt <= '0;
      end else if (st.advance) begin
        colQ    <= colNext;
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  generate
    if (ADDR_W > COL_W) begin : g_pad
      assign colBus = {{(ADDR_W-COL_W){1'b0}}, colQ};
    end else begin : g_trim
      assign colBus = colQ[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    case (st.cmd)
      C_ACT:   begin rcw = 3'b011; sdAddr = rowQ;     end
      C_RD:    begin rcw = 3'b101; sdAddr = colBus;   end
      C_WR:    begin rcw = 3'b100; sdAddr = colBus;   end
      C_PRE:   begin rcw = 3'b010; sdAddr = PRE_ADDR; end
      default: begin rcw = 3'b111; sdAddr = '0;       end
    endcase
  end

  assign {sdRasN, sdCasN, sdWeN} = rcw;
  assign sdCsN    = ~st.busy;
  assign sdBa     = st.busy ? bankQ : '0;
  assign wrAccept = (st.cmd == C_WR);
  assign rdValid  = rdPipe[casLatQ];

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int ROW_W    = 12,
  parameter int BANK_W   = 2,
  parameter int BYTE_W   = 2,
  parameter int SZ_W     = 2,
  parameter int LAT_W    = 2,
  parameter int PRE_WAIT = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  output logic                                 reqReady,
  input  logic                                 reqWrite,
  input  logic [BYTE_W+COL_W+ROW_W+BANK_W-1:0] reqAddr,
  input  logic [SZ_W-1:0]                      reqSize,
  input  logic [LAT_W-1:0]                     casLat,
  output logic                                 done,
  output logic                                 wrAccept,
  output logic                                 rdValid,
  output logic                                 sdCsN,
  output logic                                 sdRasN,
  output logic                                 sdCasN,
  output logic                                 sdWeN,
  output logic [BANK_W-1:0]                    sdBa,
  output logic [ROW_W-1:0]                     sdAddr
);

  seq_strobe_t     st;
  logic            writeQ;
  logic            lastBeat;
  logic [LAT_W-1:0] casLatQ;

  sbs_ctrl #(.LAT_W(LAT_W), .PRE_WAIT(PRE_WAIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .writeQ   (writeQ),
    .lastBeat (lastBeat),
    .casLatQ  (casLatQ),
    .st       (st),
    .reqReady (reqReady),
    .done     (done)
  );

  sbs_dpath #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
    .BYTE_W(BYTE_W), .SZ_W(SZ_W), .LAT_W(LAT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .casLat   (casLat),
    .writeQ   (writeQ),
    .lastBeat (lastBeat),
    .casLatQ  (casLatQ),
    .wrAccept (wrAccept),
    .rdValid  (rdValid),
    .sdCsN    (sdCsN),
    .sdRasN   (sdRasN),
    .sdCasN   (sdCasN),
    .sdWeN    (sdWeN),
    .sdBa     (sdBa),
    .sdAddr   (sdAddr)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              done,
  input logic              wrAccept,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic [BANK_W-1:0] sdBa,
  input logic [ROW_W-1:0]  sdAddr
);

  logic isAct, isRd, isWr, isPre, isNop, isCol;
  logic pageOpen;

  assign isAct = !sdCsN && ({sdRasN, sdCasN, sdWeN} == 3'b011);
  assign isRd  = !sdCsN && ({sdRasN, sdCasN, sdWeN} == 3'b101);
  assign isWr  = !sdCsN && ({sdRasN, sdCasN, sdWeN} == 3'b100);
  assign isPre = !sdCsN && ({sdRasN, sdCasN, sdWeN} == 3'b010);
  assign isNop = ({sdRasN, sdCasN, sdWeN} == 3'b111);
  assign isCol = isRd || isWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageOpen <= 1'b0;
    else if (isAct) pageOpen <= 1'b1;
    else if (isPre) pageOpen <= 1'b0;
  end

  p_single_act_r3: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> !pageOpen);
  p_col_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> pageOpen);
  p_col_qual_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> !sdAddr[10]);
  p_pre_qual_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> sdAddr[10]);
  p_done_at_pre_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> isPre);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sdCsN && isNop && !done));
  p_wr_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |-> isWr);
  p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    isCol |=> (!isCol || $stable(sdBa)));

endmodule

bind sdram_burst_seq sbs_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .done     (done),
  .wrAccept (wrAccept),
  .sdCsN    (sdCsN),
  .sdRasN   (sdRasN),
  .sdCasN   (sdCasN),
  .sdWeN    (sdWeN),
  .sdBa     (sdBa),
  .sdAddr   (sdAddr)
);

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;

  localparam int COL_W = 8, ROW_W = 12, BANK_W = 2, BYTE_W = 2;
  localparam int SZ_W = 2, LAT_W = 2, PRE_WAIT = 2;
  localparam int HOST_AW = BYTE_W + COL_W + ROW_W + BANK_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [HOST_AW-1:0] reqAddr = '0;
  logic [SZ_W-1:0] reqSize = '0;
  logic [LAT_W-1:0] casLat = '0;
  logic reqReady, done, wrAccept, rdValid;
  logic sdCsN, sdRasN, sdCasN, sdWeN;
  logic [BANK_W-1:0] sdBa;
  logic [ROW_W-1:0] sdAddr;

  always #2.5 clk = ~clk;

  sdram_burst_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .casLat(casLat),
    .done(done), .wrAccept(wrAccept), .rdValid(rdValid),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr)
  );

  typedef struct packed {
    logic              csN;
    logic [2:0]        rcw;
    logic [ROW_W-1:0]  addr;
    logic [BANK_W-1:0] ba;
    logic              dn;
    logic              wr;
  } exp_t;

  exp_t expQ[$];
  logic [63:0] rdSched = '0;
  int checks = 0, fails = 0, cycles = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog run did not finish");
      report();
    end
  end

  function automatic exp_t mk(input logic [2:0] rcw, input logic [ROW_W-1:0] a,
                              input logic [BANK_W-1:0] b, input logic d, input logic w);
    exp_t e;
    e.csN = 1'b0; e.rcw = rcw; e.addr = a; e.ba = b; e.dn = d; e.wr = w;
    return e;
  endfunction

  // compare one cycle against the model, then advance the model by one cycle
  task automatic compareCycle(output logic wasIdle);
    exp_t e;
    wasIdle = (expQ.size() == 0);
    if (wasIdle) begin
      e = '0; e.csN = 1'b1; e.rcw = 3'b111;
    end else e = expQ.pop_front();
    chk("R2", "csN", sdCsN, e.csN);
    chk("R2", "cmd", {sdRasN, sdCasN, sdWeN}, e.rcw);
    chk("R6", "addr", sdAddr, e.addr);
    chk("R11", "bank", sdBa, e.ba);
    chk("R8", "done", done, e.dn);
    chk("R9", "reqReady", reqReady, wasIdle);
    chk("R10", "wrAccept", wrAccept, e.wr);
    chk("R10", "rdValid", rdValid, rdSched[0]);
    rdSched = rdSched >> 1;
  endtask

  task automatic pushXfer(input logic [HOST_AW-1:0] a, input logic w,
                          input logic [SZ_W-1:0] s, input logic [LAT_W-1:0] cl);
    int lat = int'(cl) + 1;
    int n = 1 << s;
    int mask = n - 1;
    int col0 = int'(a[BYTE_W +: COL_W]);
    logic [ROW_W-1:0] row = a[BYTE_W+COL_W +: ROW_W];
    logic [BANK_W-1:0] bank = a[HOST_AW-1 -: BANK_W];
    expQ.push_back(mk(3'b011, row, bank, 1'b0, 1'b0));            // R3 ACTIVE
    for (int i = 0; i < lat - 1; i++) expQ.push_back(mk(3'b111, '0, bank, 1'b0, 1'b0)); // R4
    for (int i = 0; i < n; i++) begin                              // R5 beats
      int col = (col0 & ~mask) | ((col0 + i) & mask);              // R6 wrap
      if (!w) rdSched[expQ.size() + lat] = 1'b1;                   // R10
      expQ.push_back(mk(w ? 3'b100 : 3'b101, ROW_W'(col), bank, 1'b0, w));
    end
    expQ.push_back(mk(3'b010, ROW_W'(1) << 10, bank, 1'b1, 1'b0)); // R7, R8
    for (int i = 0; i < PRE_WAIT; i++) expQ.push_back(mk(3'b111, '0, bank, 1'b0, 1'b0));
  endtask

  task automatic step(input logic v, input logic [HOST_AW-1:0] a, input logic w,
                      input logic [SZ_W-1:0] s, input logic [LAT_W-1:0] cl,
                      output logic accepted);
    logic idle;
    @(negedge clk);
    compareCycle(idle);
    reqValid = v; reqAddr = a; reqWrite = w; reqSize = s; casLat = cl;
    accepted = idle && v;
    if (accepted) pushXfer(a, w, s, cl);
  endtask

  // R12: held pending during the previous transfer with differing fields
  task automatic doXfer(input logic [HOST_AW-1:0] a, input logic w,
                        input logic [SZ_W-1:0] s, input logic [LAT_W-1:0] cl);
    logic acc = 1'b0;
    while (!acc) step(1'b1, a, w, s, cl, acc);
  endtask

  task automatic gap(input int n);
    logic acc;
    for (int i = 0; i < n; i++)
      step(1'b0, HOST_AW'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), acc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "csN", sdCsN, 1);
    chk("R1", "cmd", {sdRasN, sdCasN, sdWeN}, 3'b111);
    chk("R1", "reqReady", reqReady, 1);
    chk("R1", "done", done, 0);
    chk("R1", "wrAccept", wrAccept, 0);
    chk("R1", "rdValid", rdValid, 0);
    rstN = 1'b1;
    gap(3);
    // R3 R4 R5 R6 R7: every latency and size, read and write
    for (int cl = 0; cl < 4; cl++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++) begin
          doXfer(HOST_AW'($urandom), 1'(w), 2'(s), 2'(cl));
          if (((cl + s + w) % 3) == 0) gap(2);
        end
    // R6 mid-block start, eight beats, wraps after column 0x5F
    doXfer({2'b10, 12'hABC, 8'h5D, 2'b11}, 1'b0, 2'd3, 2'd1);
    doXfer({2'b01, 12'h123, 8'hFE, 2'b00}, 1'b1, 2'd2, 2'd3);
    gap(14);
    report();
  end

endmodule